// File: doc/BRIEF.md
# Four-and-a-half-decade event counter with store latch

The block counts rising edges on an asynchronous event input and holds a decimal result from 0 to 19999. The result is kept in four biquinary decades and one extra half-digit bit that carries the ten-thousands place. Each decade is a divide-by-two stage feeding a divide-by-five stage. Its binary-coded digit is put together from the states of those two stages. A separate output latch takes a copy of the live count only when a store request is accepted, so the outputs stay still while counting goes on beneath them.

The event input, the store request and the clear request are all treated as asynchronous. Each one passes through a synchronizer chain clocked by the system clock. The store and clear requests must also stay high for a minimum number of clock cycles before they are accepted. A request that is accepted acts once per pulse, however long the pulse is held. The inhibit input is synchronous to the clock and gates only the first stage of the lowest decade. A one-cycle carry pulse lets several blocks be chained into wider counters.

This block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `biq_event_counter`

## Requirements
- R1: While rst_n is low, and after it is released with no stimulus, digits_o is 0, half_o is 0 and carry_o is 0.
- R2: Each rising edge on count_in adds one to the live count when inhibit is low. The edge must be held at least two clocks high and then two clocks low.
- R3: Count edges that arrive while inhibit is high are ignored, and the live count keeps its value.
- R4: digits_o and half_o change only when a store request is accepted. Counting without a store leaves them unchanged.
- R5: A store request held high for fewer than STROBE_MIN clock cycles has no effect. One held for STROBE_MIN cycles or more copies the live count into the output latch exactly once.
- R6: A clear request held for fewer than STROBE_MIN cycles has no effect. An accepted clear sets every decade and the half-digit bit of the live count to zero and leaves the output latch alone.
- R7: When the count goes from 9999 to 10000, the half-digit bit becomes 1 and carry_o is high for exactly one clock.
- R8: When the count goes past 19999, it wraps to 0 and the half-digit bit goes back to 0. carry_o pulses for one clock here as well.
- R9: If a store and a clear are accepted in the same cycle, the latch receives the value the count had before the clear.
- R10: digits_o[4k+3:4k] holds decade k in BCD, where k=0 is the units place. Every digit is always in the range 0..9, and half_o is the ten-thousands place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for all state |
| count_in | input | 1 | Asynchronous event input; each rising edge is counted |
| inhibit | input | 1 | Synchronous; when high, it blocks the first counter stage |
| store_req | input | 1 | Asynchronous request to copy the live count into the latch |
| clear_req | input | 1 | Asynchronous request to set the live count to zero |
| digits_o | output | 4*DECADES | Latched BCD digits, units in the low nibble |
| half_o | output | 1 | Latched half-digit (ten-thousands) bit |
| carry_o | output | 1 | One-cycle pulse each time the top decade rolls over |

## Verification
The bench checks the two rollovers at the top of the range. At 9999 to 10000, a design that loses the top carry would show 0 with no half digit. At 19999 to 0, a design that saturates, or that does not toggle the half-digit bit back, would show the wrong value. The bench also counts the cycles where carry is high, so a carry that lasts longer than one clock shows up as a wrong count. It sends store and clear pulses that are one cycle short of the minimum, which a filter with an off-by-one error would wrongly accept. It sends a store and a clear in the same cycle, where giving clear priority would latch zero instead of the old count. It sends edges while inhibit is high, which a design that gates the wrong stage would still count.

// File: rtl/biq_pkg.sv
package biq_pkg;
  typedef logic [3:0] bcd_t;
  localparam int unsigned QUINARY_TOP = 4;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/strobe_qualify.sv
module strobe_qualify #(
  parameter int unsigned MIN_CYC = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!req_i)       run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  // fires once, on the MIN_CYC-th consecutive high sample
  assign fire_o = req_i && (run_q == LAST);
endmodule

// File: rtl/biq_decade.sv
module biq_decade
  import biq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output bcd_t bcd_o,
  output logic cout_o
);
  logic       bin_q;
  logic [2:0] quin_q;

  assign cout_o = en_i && bin_q && (quin_q == 3'(QUINARY_TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= 1'b0;
      quin_q <= '0;
    end else if (clr_i) begin
      bin_q  <= 1'b0;
      quin_q <= '0;
    end else if (en_i) begin
      bin_q <= ~bin_q;
      if (bin_q)
        quin_q <= (quin_q == 3'(QUINARY_TOP)) ? 3'd0 : quin_q + 3'd1;
    end
  end

  // value = 2*quinary + binary
  assign bcd_o = {quin_q, bin_q};
endmodule

// File: rtl/biq_event_counter.sv
module biq_event_counter
  import biq_pkg::*;
#(
  parameter int unsigned DECADES     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STROBE_MIN  = 750
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 count_in,
  input  logic                 inhibit,
  input  logic                 store_req,
  input  logic                 clear_req,
  output logic [4*DECADES-1:0] digits_o,
  output logic                 half_o,
  output logic                 carry_o
);
  localparam int unsigned DW = 4 * DECADES;

  logic cnt_sync, cnt_prev, store_sync, clear_sync;
  logic store_go, clear_go, tick;
  logic [DECADES:0] en_chain;
  logic [DW-1:0]    live;
  logic             half_live;

  sync_chain #(.STAGES(SYNC_STAGES)) i_sync_cnt (
    .clk(clk), .rst_n(rst_n), .d_i(count_in), .q_o(cnt_sync));
  sync_chain #(.STAGES(SYNC_STAGES)) i_sync_st (
    .clk(clk), .rst_n(rst_n), .d_i(store_req), .q_o(store_sync));
  sync_chain #(.STAGES(SYNC_STAGES)) i_sync_cl (
    .clk(clk), .rst_n(rst_n), .d_i(clear_req), .q_o(clear_sync));

  strobe_qualify #(.MIN_CYC(STROBE_MIN)) i_q_store (
    .clk(clk), .rst_n(rst_n), .req_i(store_sync), .fire_o(store_go));
  strobe_qualify #(.MIN_CYC(STROBE_MIN)) i_q_clear (
    .clk(clk), .rst_n(rst_n), .req_i(clear_sync), .fire_o(clear_go));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev <= 1'b0;
    else        cnt_prev <= cnt_sync;
  end

  // inhibit and clear only gate the very first stage
  assign tick        = cnt_sync && !cnt_prev && !inhibit && !clear_go;
  assign en_chain[0] = tick;

  for (genvar k = 0; k < DECADES; k++) begin : g_dec
    biq_decade i_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clear_go),
      .en_i  (en_chain[k]),
      .bcd_o (live[4*k +: 4]),
      .cout_o(en_chain[k+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_live <= 1'b0;
      carry_o   <= 1'b0;
    end else begin
      carry_o <= en_chain[DECADES];
      if (clear_go)              half_live <= 1'b0;
      else if (en_chain[DECADES]) half_live <= ~half_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digits_o <= '0;
      half_o   <= 1'b0;
    end else if (store_go) begin
      digits_o <= live;
      half_o   <= half_live;
    end
  end
endmodule

// File: rtl/biq_event_counter_chk.sv
module biq_event_counter_chk #(
  parameter int unsigned DECADES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inhibit,
  input logic                 store_go,
  input logic                 clear_go,
  input logic [4*DECADES-1:0] live,
  input logic                 half_live,
  input logic [4*DECADES-1:0] digits_o,
  input logic                 half_o,
  input logic                 carry_o
);
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !store_go |=> $stable({half_o, digits_o}));

  a_r3_inhibit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !clear_go) |=> $stable({half_live, live}));

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear_go |=> (live == '0 && !half_live));

  a_r7_carry_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  a_r8_carry_toggles_half: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (half_live != $past(half_live)));

  a_r9_store_gets_old: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> ({half_o, digits_o} == $past({half_live, live})));

  for (genvar k = 0; k < DECADES; k++) begin : g_legal
    a_r10_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (live[4*k +: 4] <= 4'd9) && (digits_o[4*k +: 4] <= 4'd9));
  end
endmodule

bind biq_event_counter biq_event_counter_chk #(.DECADES(DECADES)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inhibit  (inhibit),
  .store_go (store_go),
  .clear_go (clear_go),
  .live     (live),
  .half_live(half_live),
  .digits_o (digits_o),
  .half_o   (half_o),
  .carry_o  (carry_o)
);

// File: tb/test_biq_event_counter.sv
`timescale 1ns/1ps
module test_biq_event_counter;
  localparam int unsigned DEC = 4;
  localparam int unsigned MINW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_in = 1'b0, inhibit = 1'b0, store_req = 1'b0, clear_req = 1'b0;
  logic [4*DEC-1:0] digits_o;
  logic half_o, carry_o;

  always #2 clk = ~clk;

  biq_event_counter #(.DECADES(DEC), .SYNC_STAGES(2), .STROBE_MIN(MINW)) i_biq_event_counter (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .inhibit(inhibit),
    .store_req(store_req), .clear_req(clear_req),
    .digits_o(digits_o), .half_o(half_o), .carry_o(carry_o));

  int n_vec = 0, n_bad = 0;
  int model = 0;
  int carry_seen = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  event chk_ev;
  bit done = 0;

  function automatic logic [16:0] encode(int v);
    logic [16:0] r;
    int rest;
    rest = v % 10000;
    r[16] = (v >= 10000);
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return r;
  endfunction

  // monitor: pops expected latched values and compares
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({half_o, digits_o} !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, {half_o, digits_o}, e);
      end
    end
  end

  always @(negedge clk) if (rst_n && carry_o) carry_seen++;

  task automatic expect_out(int v, string t);
    exp_q.push_back(encode(v));
    tag_q.push_back(t);
    -> chk_ev;
    #0;
  endtask

  task automatic check_carry(int want, string t);
    n_vec++;
    if (carry_seen != want) begin
      n_bad++;
      $display("FAIL %s: carry cycles %0d expected %0d", t, carry_seen, want);
    end
  endtask

  task automatic pulse_count(int n, bit counted);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) count_in = 1'b1;
      repeat (2) @(negedge clk);
      count_in = 1'b0;
      @(negedge clk);
      if (counted) model = (model + 1) % 20000;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe(bit st, bit cl, int len);
    @(negedge clk);
    store_req = st; clear_req = cl;
    repeat (len) @(negedge clk);
    store_req = 1'b0; clear_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (digits_o !== '0 || half_o !== 1'b0 || carry_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset got %h/%b/%b expected 0/0/0", digits_o, half_o, carry_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(0, "R1 after release");
    check_carry(0, "R1 no carry");

    pulse_count(5, 1);
    expect_out(0, "R4 no store yet");
    strobe(1, 0, MINW);
    expect_out(5, "R2 five edges");

    inhibit = 1'b1;
    pulse_count(3, 0);
    inhibit = 1'b0;
    repeat (2) @(negedge clk);
    strobe(1, 0, MINW);
    expect_out(5, "R3 inhibited edges");

    pulse_count(7, 1);
    strobe(1, 0, MINW - 1);
    expect_out(5, "R5 short store ignored");
    strobe(1, 0, MINW + 4);
    expect_out(12, "R5 long store once");

    strobe(0, 1, MINW - 1);
    strobe(1, 0, MINW);
    expect_out(12, "R6 short clear ignored");
    strobe(0, 1, MINW);
    model = 0;
    expect_out(12, "R6 clear keeps latch");
    strobe(1, 0, MINW);
    expect_out(0, "R6 clear zeroes count");

    pulse_count(37, 1);
    strobe(1, 1, MINW);
    expect_out(37, "R9 store with clear");
    model = 0;
    strobe(1, 0, MINW);
    expect_out(0, "R9 clear applied");

    pulse_count(1234, 1);
    strobe(1, 0, MINW);
    expect_out(1234, "R10 digit placement");

    pulse_count(9999 - 1234, 1);
    strobe(1, 0, MINW);
    expect_out(9999, "R10 all nines");
    check_carry(0, "R7 no early carry");
    pulse_count(1, 1);
    check_carry(1, "R7 carry at 10000");
    strobe(1, 0, MINW);
    expect_out(10000, "R7 half digit set");

    pulse_count(9999, 1);
    strobe(1, 0, MINW);
    expect_out(19999, "R8 top of range");
    pulse_count(1, 1);
    check_carry(2, "R8 carry at wrap");
    strobe(1, 0, MINW);
    expect_out(0, "R8 wrap to zero");

    pulse_count(3, 1);
    strobe(1, 0, MINW);
    expect_out(3, "R2 counting after wrap");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule